// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the moment an external signal changes state. It samples the running count of one of two free-running 16-bit timers into a holding register whenever a qualifying transition appears on a single-bit event input. A 4-bit mode field sets which transitions qualify: each falling edge, each rising edge, every fourth rising edge or every sixteenth rising edge. Every other mode code turns capture off. A select bit chooses which of the two timer buses supplies the count.

The event input is asynchronous. It passes through a two-flop synchronizer, and a one-cycle edge detector follows. The qualification logic sees only clean single-cycle pulses. Each capture raises a sticky interrupt flag, which software clears with a one-cycle strobe. The holding register is reached over a byte-wide bus as two 8-bit halves. Software can write either half. A later capture overwrites the whole register, even if the previous value was never read.

Top module: `tcap_top`

## Requirements
- R1: After synchronous reset, the flag is 0, the capture register holds 0 and `rd_data` reads 0.
- R2: A level change on `evt_in`, set up before clock edge k, is registered by the two-flop synchronizer at edges k and k+1. The edge detector then turns it into a one-cycle pulse. A qualifying change is captured at edge k+2, with the timer value present at that edge. The capture adds no further latency.
- R3: With mode 4'b0100, each falling edge of the input is captured. With mode 4'b0101, each rising edge is captured. The capture stores all 16 bits of the selected timer.
- R4: When `tmr_sel` is 0, the count comes from `tmr_a`. When it is 1, the count comes from `tmr_b`. The select is sampled in the capture cycle.
- R5: With mode 4'b0110, capture happens on every 4th rising edge. With mode 4'b0111, it happens on every 16th rising edge. Counting starts from a cleared prescaler.
- R6: The prescaler is cleared in any cycle where the mode differs from its value in the previous cycle, and in any cycle where a prescaled mode is not active. An edge that arrives in a mode-change cycle never qualifies.
- R7: Any mode code other than 4'b0100 to 4'b0111 disables capture. Edges then change neither the register nor the flag.
- R8: Each capture sets `cap_flag`. The flag stays set until `flag_clr` is pulsed.
- R9: If `flag_clr` and a capture occur in the same cycle, the flag stays set.
- R10: A new capture overwrites the register, and the earlier value is lost.
- R11: When `wr_en` is high, `wr_data` is written into the low byte if `wr_hi` is 0, or into the high byte if `wr_hi` is 1. A capture in the same cycle takes precedence over the write.
- R12: `rd_data` is registered. It shows the high byte if `rd_hi` was 1 at the previous edge, and the low byte otherwise, as the register stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | 1 | Asynchronous event pin |
| tmr_a | input | 16 | Count of timer A |
| tmr_b | input | 16 | Count of timer B |
| tmr_sel | input | 1 | 0 selects timer A, 1 selects timer B |
| mode | input | 4 | Event qualification code |
| wr_en | input | 1 | Software write strobe for the capture register |
| wr_hi | input | 1 | Write byte select, 1 selects the high byte |
| wr_data | input | 8 | Write data byte |
| rd_hi | input | 1 | Read byte select, 1 selects the high byte |
| rd_data | output | 8 | Registered read data |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| cap_flag | output | 1 | Sticky capture interrupt flag |

## Verification
The bench targets the prescaler boundaries. It checks that the 4th and the 16th rising edge are captured and the edge just before is not, and it switches modes part-way through a count. A design that kept a stale count would capture too early after such a switch. The bench also pulses the clear strobe in the capture cycle, where a design with the wrong priority would drop the flag. It writes a byte in the same cycle as a capture, where the wrong priority would corrupt half of the timestamp. Exact-cycle comparisons expose any extra or missing synchronizer stage, because such a stage captures a timer value from the wrong cycle.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  typedef enum logic [3:0] {
    MODE_FALL  = 4'b0100,
    MODE_RISE  = 4'b0101,
    MODE_DIV_A = 4'b0110,
    MODE_DIV_B = 4'b0111
  } tcap_mode_e;

  function automatic logic mode_enabled(input logic [3:0] m);
    return (m == MODE_FALL) || (m == MODE_RISE) ||
           (m == MODE_DIV_A) || (m == MODE_DIV_B);
  endfunction

  function automatic logic mode_divided(input logic [3:0] m);
    return (m == MODE_DIV_A) || (m == MODE_DIV_B);
  endfunction
endpackage

// File: rtl/tcap_sync_edge.sv
module tcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise_p,
  output logic fall_p
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  // synchronizer chain, oldest sample at the top bit
  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  always_comb begin
    rise_p = sync_q[STAGES-1] & ~prev_q;
    fall_p = ~sync_q[STAGES-1] & prev_q;
  end

  // an edge pulse never lasts two cycles in a row
  assert_pulse_single_R2: assert property (@(posedge clk) disable iff (rst)
    (rise_p | fall_p) |=> !($past(rise_p) && rise_p) && !($past(fall_p) && fall_p));
endmodule

// File: rtl/tcap_qualify.sv
module tcap_qualify
  import tcap_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode,
  input  logic       rise_p,
  input  logic       fall_p,
  output logic       qual
);
  localparam int CNT_W = (DIV_B > DIV_A) ? $clog2(DIV_B) : $clog2(DIV_A);

  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       mode_q;
  logic             chg, div_md;
  logic [CNT_W-1:0] tgt;

  always_comb begin
    chg    = (mode != mode_q);
    div_md = mode_divided(mode);
    tgt    = (mode == MODE_DIV_B) ? CNT_W'(DIV_B - 1) : CNT_W'(DIV_A - 1);
    qual   = 1'b0;
    if (!chg) begin
      unique case (mode)
        MODE_FALL:              qual = fall_p;
        MODE_RISE:              qual = rise_p;
        MODE_DIV_A, MODE_DIV_B: qual = rise_p && (cnt_q == tgt);
        default:                qual = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mode_q <= 4'd0;
    end else begin
      mode_q <= mode;
      if (chg || !div_md)      cnt_q <= '0;
      else if (rise_p)         cnt_q <= (cnt_q == tgt) ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (mode != mode_q) |=> (cnt_q == '0));

  assert_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !mode_enabled(mode) |-> !qual);
endmodule

// File: rtl/tcap_store.sv
module tcap_store #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             qual,
  input  logic [TMR_W-1:0] tmr_a,
  input  logic [TMR_W-1:0] tmr_b,
  input  logic             tmr_sel,
  input  logic             wr_en,
  input  logic             wr_hi,
  input  logic [TMR_W/2-1:0] wr_data,
  input  logic             rd_hi,
  input  logic             flag_clr,
  output logic [TMR_W/2-1:0] rd_data,
  output logic             cap_flag
);
  localparam int HALF = TMR_W / 2;

  logic [TMR_W-1:0] cap_q;
  logic [TMR_W-1:0] src;
  logic [HALF-1:0]  rd_q;
  logic             flag_q;

  assign src = tmr_sel ? tmr_b : tmr_a;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q  <= '0;
      rd_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      rd_q <= rd_hi ? cap_q[TMR_W-1:HALF] : cap_q[HALF-1:0];
      if (qual)                cap_q <= src;
      else if (wr_en && wr_hi) cap_q[TMR_W-1:HALF] <= wr_data;
      else if (wr_en)          cap_q[HALF-1:0] <= wr_data;
      if (qual)                flag_q <= 1'b1;
      else if (flag_clr)       flag_q <= 1'b0;
    end
  end

  assign rd_data  = rd_q;
  assign cap_flag = flag_q;

  assert_cap_load_R3: assert property (@(posedge clk) disable iff (rst)
    qual |=> cap_q == $past(tmr_sel ? tmr_b : tmr_a));

  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    qual |=> flag_q);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !flag_clr) |=> flag_q);

  assert_cap_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (!qual && !wr_en) |=> $stable(cap_q));
endmodule

// File: rtl/tcap_top.sv
module tcap_top #(
  parameter int TMR_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_A       = 4,
  parameter int DIV_B       = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        evt_in,
  input  logic [15:0] tmr_a,
  input  logic [15:0] tmr_b,
  input  logic        tmr_sel,
  input  logic [3:0]  mode,
  input  logic        wr_en,
  input  logic        wr_hi,
  input  logic [7:0]  wr_data,
  input  logic        rd_hi,
  output logic [7:0]  rd_data,
  input  logic        flag_clr,
  output logic        cap_flag
);
  logic rise_p, fall_p, qual;

  tcap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .din(evt_in), .rise_p(rise_p), .fall_p(fall_p)
  );

  tcap_qualify #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_qual (
    .clk(clk), .rst(rst), .mode(mode), .rise_p(rise_p), .fall_p(fall_p), .qual(qual)
  );

  tcap_store #(.TMR_W(TMR_W)) u_store (
    .clk(clk), .rst(rst), .qual(qual), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .tmr_sel(tmr_sel), .wr_en(wr_en), .wr_hi(wr_hi), .wr_data(wr_data),
    .rd_hi(rd_hi), .flag_clr(flag_clr), .rd_data(rd_data), .cap_flag(cap_flag)
  );
endmodule

// File: tb/tcap_top_tb.sv
`timescale 1ns/1ps
module tcap_top_tb;
  logic clk = 0, rst = 1;
  logic evt_in = 0, tmr_sel = 0, wr_en = 0, wr_hi = 0, rd_hi = 0, flag_clr = 0;
  logic [15:0] tmr_a = 0, tmr_b = 0;
  logic [3:0]  mode = 0;
  logic [7:0]  wr_data = 0;
  logic [7:0]  rd_data;
  logic        cap_flag;

  always #2 clk = ~clk;

  tcap_top u_dut (
    .clk(clk), .rst(rst), .evt_in(evt_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
    .tmr_sel(tmr_sel), .mode(mode), .wr_en(wr_en), .wr_hi(wr_hi),
    .wr_data(wr_data), .rd_hi(rd_hi), .rd_data(rd_data),
    .flag_clr(flag_clr), .cap_flag(cap_flag)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  // reference model built from the requirements
  logic m_s1, m_s2, m_p, m_flag;
  logic [15:0] m_cap;
  logic [7:0]  m_rd;
  logic [3:0]  m_mode_q;
  int          m_cnt;

  function automatic bit is_div(input logic [3:0] m);
    return (m == 4'b0110) || (m == 4'b0111);
  endfunction

  always @(posedge clk) begin
    logic r, f, q, chg;
    int tgt;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_p = 0; m_flag = 0; m_cap = 0; m_rd = 0;
      m_mode_q = 0; m_cnt = 0;
    end else begin
      r = m_s2 & !m_p;
      f = !m_s2 & m_p;
      chg = (mode != m_mode_q);
      tgt = (mode == 4'b0111) ? 15 : 3;
      q = !chg && ((mode == 4'b0100 && f) || (mode == 4'b0101 && r) ||
                   (is_div(mode) && r && m_cnt == tgt));
      m_rd = rd_hi ? m_cap[15:8] : m_cap[7:0];
      if (chg || !is_div(mode)) m_cnt = 0;
      else if (r) m_cnt = (m_cnt == tgt) ? 0 : m_cnt + 1;
      if (q) m_cap = tmr_sel ? tmr_b : tmr_a;
      else if (wr_en && wr_hi) m_cap[15:8] = wr_data;
      else if (wr_en) m_cap[7:0] = wr_data;
      if (q) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      m_mode_q = mode;
      m_p = m_s2; m_s2 = m_s1; m_s1 = evt_in;
    end
  end

  task automatic compare();
    checks++;
    if (cap_flag !== m_flag) begin
      fails++;
      $display("FAIL %s cap_flag actual=%0b expected=%0b at %0t", tag, cap_flag, m_flag, $time);
    end
    checks++;
    if (rd_data !== m_rd) begin
      fails++;
      $display("FAIL %s rd_data actual=%02h expected=%02h at %0t", tag, rd_data, m_rd, $time);
    end
  endtask

  // one clock, compare at the falling edge, return there for driving
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
      tmr_a = tmr_a + 16'd7;
      tmr_b = tmr_b + 16'd3;
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      evt_in = 1; step(3);
      evt_in = 0; step(3);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    tmr_a = 16'h1234; tmr_b = 16'hA5C3;
    repeat (3) @(negedge clk);
    rst = 0;
    tag = "R1"; step(2);
    // R2/R3 rising edge, read both halves
    mode = 4'b0101; step(2);
    tag = "R2"; evt_in = 1; step(3); rd_hi = 1; step(2); rd_hi = 0; step(2);
    tag = "R3"; evt_in = 0; step(4);
    mode = 4'b0100; step(2); edges(2);
    // R4 source select
    tag = "R4"; tmr_sel = 1; mode = 4'b0101; step(2); edges(2); rd_hi = 1; step(2);
    tmr_sel = 0; rd_hi = 0;
    // R5 prescaled modes
    tag = "R5"; flag_clr = 1; step(1); flag_clr = 0;
    mode = 4'b0110; step(2); edges(3); edges(1); edges(4);
    mode = 4'b0111; step(2); edges(15); edges(1);
    // R6 mode change mid-count
    tag = "R6"; mode = 4'b0110; step(2); edges(2);
    mode = 4'b0111; step(1); mode = 4'b0110; step(1); edges(3); edges(1);
    mode = 4'b1111; step(2); mode = 4'b0110; step(1);
    evt_in = 1; step(1); mode = 4'b0101; step(3); evt_in = 0; step(3);
    // R7 disabled codes
    tag = "R7"; flag_clr = 1; step(1); flag_clr = 0;
    mode = 4'b0000; step(2); edges(3);
    mode = 4'b1101; step(2); edges(3);
    // R8/R9 flag behaviour
    tag = "R8"; mode = 4'b0101; step(2); edges(1); step(5);
    flag_clr = 1; step(1); flag_clr = 0; step(2);
    tag = "R9"; evt_in = 1; step(2); flag_clr = 1; step(1); flag_clr = 0; step(3);
    evt_in = 0; step(3);
    // R10 overwrite without read
    tag = "R10"; edges(1); edges(1);
    // R11 software writes and write/capture collision
    tag = "R11"; wr_en = 1; wr_hi = 0; wr_data = 8'h5A; step(1);
    wr_hi = 1; wr_data = 8'hC7; step(1); wr_en = 0; step(2);
    evt_in = 1; step(2); wr_en = 1; wr_hi = 1; wr_data = 8'hEE; step(1); wr_en = 0;
    rd_hi = 1; step(2);
    // R12 read select follows previous cycle
    tag = "R12"; rd_hi = 0; step(1); rd_hi = 1; step(1); rd_hi = 0; step(2);
    evt_in = 0; step(3);
    // constrained random phase
    tag = "R3 R5 R6 R11 random";
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk); @(negedge clk); compare();
      if ($urandom_range(2) == 0) evt_in = ~evt_in;
      tmr_a = 16'($urandom); tmr_b = 16'($urandom);
      if ($urandom_range(19) == 0) tmr_sel = ~tmr_sel;
      if ($urandom_range(79) == 0)
        mode = ($urandom_range(3) == 0) ? 4'($urandom) : 4'(4 + $urandom_range(3));
      flag_clr = ($urandom_range(7) == 0);
      wr_en = ($urandom_range(15) == 0);
      wr_hi = 1'($urandom); wr_data = 8'($urandom); rd_hi = 1'($urandom);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule